// File: doc/BRIEF.md
# Debug Run Control Unit

This block sits between a serial debug channel and a small 16-bit CPU and decides whether the CPU runs or stands still. The debug channel writes an 8-bit control word and reads back control, status and identification words. From the control word and from several stop events, the block drives a halt request into the CPU pipeline. It can also request a one-cycle CPU reset and export a freeze level that peripherals honour while the CPU is stopped.

A halt can come from five places: an explicit halt command, the end of a single step, a fetch of the reserved breakpoint opcode, the release of a system reset, or a stop from an external hardware breakpoint unit. Each non-command source leaves its own sticky pending flag. The debug side clears a flag by writing 1 to it. An active-low style enable input, taken through an optional two-flop synchronizer, holds all of the block's state at its defaults while low.

Top module: `dbg_run_ctrl`

## Requirements
- R1: A control write (write select 0) with bit 0 set raises halt_cmd on the next cycle. A control write with bit 1 set releases it, unless a stop event occurs in the same cycle. Stop events take priority over release.
- R2: A control write with bit 2 set, while halted, drops halt_cmd. halt_cmd rises again in the cycle after the first cycle in which inst_boundary is high.
- R3: While control bit 3 is set, a fetch_valid cycle with fetch_opcode equal to 16'h4343 raises halt_cmd on the next cycle and sets status bit 3. While bit 3 is clear, the same fetch has no effect on halt_cmd.
- R4: While control bit 5 is set, any cycle with sys_rst high halts the CPU. Control bit 5 comes out of reset at the value of parameter RST_BRK_DEFAULT, which defaults to 1. A cycle with sys_rst high always sets status bit 1.
- R5: A high bit i of hwbrk_stop halts the CPU on the next cycle and sets status bit 4+i.
- R6: Writing the status word (write select 1) clears each pending flag whose bit is 1 in the data. An event on the same cycle wins over the clear.
- R7: freeze equals control bit 4 ANDed with the halted state.
- R8: A control write with bit 6 set produces cpu_reset high for exactly the following cycle.
- R9: While the synchronized dbg_enable is low, all state returns to its defaults. With SYNC_EN=1, the state is cleared on the third rising edge after dbg_enable falls.
- R10: rd_sel selects the read word. A value of 0 gives the control word, with bits 3, 4 and 5 holding the stored enables and the command bits reading 0. A value of 1 gives the status word: bit 0 live halted, bit 1 reset pending, bit 3 software-break pending, bits 4 and up hardware pending. A value of 2 gives {8'h00, USER_VER, 3'h2}. A value of 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_enable | input | 1 | Debug enable, asynchronous; low holds the block at defaults |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read word select |
| rd_data | output | 16 | Read word |
| fetch_valid | input | 1 | An opcode is being fetched this cycle |
| fetch_opcode | input | 16 | Fetched opcode |
| inst_boundary | input | 1 | An instruction completed this cycle |
| sys_rst | input | 1 | System reset active |
| hwbrk_stop | input | NUM_HWBRK | Stop requests from hardware breakpoint units |
| halt_cmd | output | 1 | Halt request to the CPU |
| cpu_reset | output | 1 | One-cycle debug CPU reset |
| freeze | output | 1 | Peripheral freeze while halted |

## Verification
A directed pass drives each halt source on its own, each followed by a release. This shows that every source sets the halted state and only its own pending bit. It then puts an event and a clear of the same flag in one cycle, which distinguishes "set wins" from "clear wins". Stepping is tried with and without an instruction boundary, to show that the re-halt waits for the boundary and does not occur one cycle later anyway. The enable is dropped with non-default enables stored, so that a missing or shortened synchronizer shows up as a wrong cycle of clearing. A long random phase then mixes writes, opcode matches, boundaries, stops and resets in the same cycles against a behavioural model.

// File: rtl/dbgrc_pkg.sv
package dbgrc_pkg;

  // Control word bit positions (debug-side decode depends on them)
  localparam int unsigned CB_HALT   = 0;
  localparam int unsigned CB_RUN    = 1;
  localparam int unsigned CB_STEP   = 2;
  localparam int unsigned CB_SWBRK  = 3;
  localparam int unsigned CB_FRZ    = 4;
  localparam int unsigned CB_RSTBRK = 5;
  localparam int unsigned CB_CPURST = 6;

  // Status word bit positions
  localparam int unsigned SB_HALTED = 0;
  localparam int unsigned SB_PUC    = 1;
  localparam int unsigned SB_SWBRK  = 3;
  localparam int unsigned SB_HW0    = 4;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned RD_W      = 16;
  localparam logic [15:0] SWBRK_OPC = 16'h4343;
  localparam logic [2:0]  CORE_REV  = 3'h2;

  typedef enum logic [1:0] {
    RD_CTRL   = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_NONE   = 2'd3
  } rd_word_e;

  // One-cycle command strobes decoded from a control write
  typedef struct packed {
    logic halt;
    logic run;
    logic step;
    logic cpurst;
  } cmd_t;

  // Stored enables of the control word
  typedef struct packed {
    logic rstbrk;
    logic frz;
    logic sw;
  } ctl_en_t;

endpackage

// File: rtl/dbgrc_sync.sv
module dbgrc_sync #(
  parameter bit SYNC_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  generate
    if (SYNC_EN) begin : g_two_flop
      logic [1:0] stage_q;
      logic [1:0] stage_d;

      always_comb begin
        stage_d = {stage_q[0], async_in};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= 2'b00;
        end else begin
          stage_q <= stage_d;
        end
      end

      assign sync_out = stage_q[1];
    end else begin : g_bypass
      assign sync_out = async_in;
    end
  endgenerate

endmodule

// File: rtl/dbgrc_flag.sv
module dbgrc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_on,
  input  logic evt,
  input  logic wclr,
  output logic q
);

  logic q_d;

  always_comb begin
    if (!dbg_on) begin
      q_d = 1'b0;
    end else if (evt) begin
      q_d = 1'b1;
    end else if (wclr) begin
      q_d = 1'b0;
    end else begin
      q_d = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/dbgrc_cfg.sv
module dbgrc_cfg
  import dbgrc_pkg::*;
#(
  parameter bit          RST_BRK_DEFAULT = 1'b1,
  parameter int unsigned NUM_HWBRK       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_on,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 puc_evt,
  input  logic                 sw_evt,
  input  logic [NUM_HWBRK-1:0] hw_evt,
  output cmd_t                 cmd,
  output ctl_en_t              en,
  output logic                 puc_pnd,
  output logic                 sw_pnd,
  output logic [NUM_HWBRK-1:0] hw_pnd
);

  localparam int unsigned NFLAG = 2 + NUM_HWBRK;

  localparam ctl_en_t EN_RESET = '{rstbrk: RST_BRK_DEFAULT, frz: 1'b0, sw: 1'b0};

  logic    wr_ctl;
  logic    wr_stat;
  ctl_en_t en_d;

  assign wr_ctl  = dbg_on & wr_en & ~wr_sel;
  assign wr_stat = dbg_on & wr_en &  wr_sel;

  // Command strobes
  always_comb begin
    cmd.halt   = wr_ctl & wr_data[CB_HALT];
    cmd.run    = wr_ctl & wr_data[CB_RUN];
    cmd.step   = wr_ctl & wr_data[CB_STEP];
    cmd.cpurst = wr_ctl & wr_data[CB_CPURST];
  end

  // Stored enables: next-state
  always_comb begin
    if (!dbg_on) begin
      en_d = EN_RESET;
    end else if (wr_ctl) begin
      en_d.sw     = wr_data[CB_SWBRK];
      en_d.frz    = wr_data[CB_FRZ];
      en_d.rstbrk = wr_data[CB_RSTBRK];
    end else begin
      en_d = en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= EN_RESET;
    end else begin
      en <= en_d;
    end
  end

  // Pending flags: one cell per source, mapped to its status bit
  logic [NFLAG-1:0] flag_evt;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;

  always_comb begin
    flag_evt[0] = puc_evt;
    flag_clr[0] = wr_stat & wr_data[SB_PUC];
    flag_evt[1] = sw_evt;
    flag_clr[1] = wr_stat & wr_data[SB_SWBRK];
  end

  generate
    for (genvar gi = 0; gi < NUM_HWBRK; gi++) begin : g_hw_map
      assign flag_evt[2+gi] = hw_evt[gi];
      assign flag_clr[2+gi] = wr_stat & wr_data[SB_HW0+gi];
    end

    for (genvar gf = 0; gf < NFLAG; gf++) begin : g_flag
      dbgrc_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbg_on (dbg_on),
        .evt    (flag_evt[gf]),
        .wclr   (flag_clr[gf]),
        .q      (flag_q[gf])
      );
    end
  endgenerate

  assign puc_pnd = flag_q[0];
  assign sw_pnd  = flag_q[1];
  assign hw_pnd  = flag_q[NFLAG-1:2];

endmodule

// File: rtl/dbgrc_runctl.sv
module dbgrc_runctl
  import dbgrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_on,
  input  cmd_t cmd,
  input  logic stop_evt,
  input  logic inst_boundary,
  output logic halted,
  output logic stepping,
  output logic cpu_reset
);

  logic halted_d;
  logic stepping_d;
  logic cpu_reset_d;
  logic step_done;
  logic halt_set;
  logic halt_clr;

  assign step_done = stepping & inst_boundary;
  assign halt_set  = cmd.halt | stop_evt | step_done;
  assign halt_clr  = cmd.run | cmd.step;

  always_comb begin
    if (!dbg_on) begin
      halted_d    = 1'b0;
      stepping_d  = 1'b0;
      cpu_reset_d = 1'b0;
    end else begin
      cpu_reset_d = cmd.cpurst;
      if (halt_set) begin
        halted_d = 1'b1;
      end else if (halt_clr) begin
        halted_d = 1'b0;
      end else begin
        halted_d = halted;
      end
      if (halt_set) begin
        stepping_d = 1'b0;
      end else if (cmd.step && halted) begin
        stepping_d = 1'b1;
      end else if (inst_boundary) begin
        stepping_d = 1'b0;
      end else begin
        stepping_d = stepping;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      stepping  <= 1'b0;
      cpu_reset <= 1'b0;
    end else begin
      halted    <= halted_d;
      stepping  <= stepping_d;
      cpu_reset <= cpu_reset_d;
    end
  end

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbgrc_pkg::*;
#(
  parameter bit          SYNC_EN         = 1'b1,
  parameter bit          RST_BRK_DEFAULT = 1'b1,
  parameter logic [4:0]  USER_VER        = 5'b00011,
  parameter int unsigned NUM_HWBRK       = 2,
  parameter int unsigned OPC_W           = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_enable,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [1:0]           rd_sel,
  output logic [RD_W-1:0]      rd_data,
  input  logic                 fetch_valid,
  input  logic [OPC_W-1:0]     fetch_opcode,
  input  logic                 inst_boundary,
  input  logic                 sys_rst,
  input  logic [NUM_HWBRK-1:0] hwbrk_stop,
  output logic                 halt_cmd,
  output logic                 cpu_reset,
  output logic                 freeze
);

  localparam logic [OPC_W-1:0] BRK_OPC = OPC_W'(SWBRK_OPC);

  logic                 dbg_on;
  cmd_t                 cmd;
  ctl_en_t              en;
  logic                 sw_brk_on;
  logic                 puc_pnd;
  logic                 sw_pnd;
  logic [NUM_HWBRK-1:0] hw_pnd;
  logic                 halted;
  logic                 stepping;
  logic                 sw_hit;
  logic                 stop_evt;
  logic [NUM_HWBRK-1:0] hw_evt;

  dbgrc_sync #(.SYNC_EN(SYNC_EN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (dbg_enable),
    .sync_out (dbg_on)
  );

  assign sw_brk_on = en.sw;
  assign sw_hit    = dbg_on & en.sw & fetch_valid & (fetch_opcode == BRK_OPC);
  assign hw_evt    = dbg_on ? hwbrk_stop : '0;
  assign stop_evt  = sw_hit | (|hw_evt) | (dbg_on & sys_rst & en.rstbrk);

  dbgrc_cfg #(
    .RST_BRK_DEFAULT (RST_BRK_DEFAULT),
    .NUM_HWBRK       (NUM_HWBRK)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbg_on  (dbg_on),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .puc_evt (dbg_on & sys_rst),
    .sw_evt  (sw_hit),
    .hw_evt  (hw_evt),
    .cmd     (cmd),
    .en      (en),
    .puc_pnd (puc_pnd),
    .sw_pnd  (sw_pnd),
    .hw_pnd  (hw_pnd)
  );

  dbgrc_runctl u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_on        (dbg_on),
    .cmd           (cmd),
    .stop_evt      (stop_evt),
    .inst_boundary (inst_boundary),
    .halted        (halted),
    .stepping      (stepping),
    .cpu_reset     (cpu_reset)
  );

  assign halt_cmd = halted;
  assign freeze   = halted & en.frz;

  // Read word mux
  always_comb begin
    rd_data = '0;
    unique case (rd_word_e'(rd_sel))
      RD_CTRL: begin
        rd_data[CB_SWBRK]  = en.sw;
        rd_data[CB_FRZ]    = en.frz;
        rd_data[CB_RSTBRK] = en.rstbrk;
      end
      RD_STATUS: begin
        rd_data[SB_HALTED] = halted;
        rd_data[SB_PUC]    = puc_pnd;
        rd_data[SB_SWBRK]  = sw_pnd;
        rd_data[SB_HW0 +: NUM_HWBRK] = hw_pnd;
      end
      RD_IDENT: begin
        rd_data[7:0] = {USER_VER, CORE_REV};
      end
      default: begin
        rd_data = '0;
      end
    endcase
  end

endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk #(
  parameter int unsigned NHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dbg_on,
  input logic           wr_en,
  input logic           wr_sel,
  input logic [7:0]     wr_data,
  input logic           fetch_valid,
  input logic [15:0]    fetch_opcode,
  input logic           sw_brk_on,
  input logic [NHW-1:0] hwbrk_stop,
  input logic           halt_cmd,
  input logic           cpu_reset,
  input logic           freeze
);

  AST_HALT_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_on && wr_en && !wr_sel && wr_data[0]) |=> halt_cmd); // R1

  AST_SWBRK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_on && sw_brk_on && fetch_valid && fetch_opcode == 16'h4343) |=> halt_cmd); // R3

  AST_HWBRK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_on && (|hwbrk_stop)) |=> halt_cmd); // R5

  AST_FREEZE_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> halt_cmd); // R7

  AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> $past(dbg_on && wr_en && !wr_sel && wr_data[6])); // R8

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_on |=> (!halt_cmd && !cpu_reset)); // R9

endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk #(.NHW(NUM_HWBRK)) u_chk (.*);

// File: tb/sim_dbg_run_ctrl.sv
module sim_dbg_run_ctrl;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        dbg_enable;
  logic        wr_en;
  logic        wr_sel;
  logic [7:0]  wr_data;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic        fetch_valid;
  logic [15:0] fetch_opcode;
  logic        inst_boundary;
  logic        sys_rst;
  logic [1:0]  hwbrk_stop;
  logic        halt_cmd;
  logic        cpu_reset;
  logic        freeze;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dbg_run_ctrl u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_enable    (dbg_enable),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .fetch_valid   (fetch_valid),
    .fetch_opcode  (fetch_opcode),
    .inst_boundary (inst_boundary),
    .sys_rst       (sys_rst),
    .hwbrk_stop    (hwbrk_stop),
    .halt_cmd      (halt_cmd),
    .cpu_reset     (cpu_reset),
    .freeze        (freeze)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  bit m_s0, m_s1;
  bit m_halt, m_step, m_rp;
  bit m_sw, m_frz, m_rbe;
  bit m_puc, m_swp;
  bit [1:0] m_hw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0;
      m_halt = 0; m_step = 0; m_rp = 0;
      m_sw = 0; m_frz = 0; m_rbe = 1;
      m_puc = 0; m_swp = 0; m_hw = 0;
    end else begin
      bit on, wc, ws, hit, setv, clrv;
      bit n_halt, n_step;
      on = m_s1;
      m_s1 = m_s0;
      m_s0 = dbg_enable;
      if (!on) begin
        m_halt = 0; m_step = 0; m_rp = 0;
        m_sw = 0; m_frz = 0; m_rbe = 1;
        m_puc = 0; m_swp = 0; m_hw = 0;
      end else begin
        wc   = wr_en && !wr_sel;
        ws   = wr_en && wr_sel;
        hit  = m_sw && fetch_valid && fetch_opcode == 16'h4343;
        setv = (wc && wr_data[0]) || hit || (hwbrk_stop != 0) ||
               (m_step && inst_boundary) || (sys_rst && m_rbe);
        clrv = wc && (wr_data[1] || wr_data[2]);
        n_halt = setv ? 1 : (clrv ? 0 : m_halt);
        if (setv) n_step = 0;
        else if (wc && wr_data[2] && m_halt) n_step = 1;
        else if (inst_boundary) n_step = 0;
        else n_step = m_step;
        m_halt = n_halt;
        m_step = n_step;
        m_rp   = wc && wr_data[6];
        m_puc   = sys_rst || (m_puc && !(ws && wr_data[1]));
        m_swp   = hit || (m_swp && !(ws && wr_data[3]));
        m_hw[0] = hwbrk_stop[0] || (m_hw[0] && !(ws && wr_data[4]));
        m_hw[1] = hwbrk_stop[1] || (m_hw[1] && !(ws && wr_data[5]));
        if (wc) begin
          m_sw = wr_data[3]; m_frz = wr_data[4]; m_rbe = wr_data[5];
        end
      end
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return {10'b0, m_rbe, m_frz, m_sw, 3'b0};
      2'd1:    return {10'b0, m_hw, m_swp, 1'b0, m_puc, m_halt};
      2'd2:    return {8'b0, 5'b00011, 3'b010};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Wait for an edge, settle, compare all outputs against the model
  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    check("R1 halt_cmd", {15'b0, halt_cmd}, {15'b0, m_halt});
    check("R7 freeze", {15'b0, freeze}, {15'b0, m_halt & m_frz});
    check("R8 cpu_reset", {15'b0, cpu_reset}, {15'b0, m_rp});
    check("R10 rd_data", rd_data, exp_rd(rd_sel));
  endtask

  task automatic wctl(input logic [7:0] d);
    wr_en = 1; wr_sel = 0; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic wstat(input logic [7:0] d);
    wr_en = 1; wr_sel = 1; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [15:0] e);
    rd_sel = s;
    #1;
    check(tag, rd_data, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; dbg_enable = 1;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    fetch_valid = 0; fetch_opcode = 0; inst_boundary = 0;
    sys_rst = 0; hwbrk_stop = 0;
    #(CLK_P * 2);
    rst_n = 1;
    repeat (3) tick();

    // Reset state and identification
    check("R1 reset halt", {15'b0, halt_cmd}, 16'h0000);
    rd_chk("R4 reset ctrl default", 2'd0, 16'h0020);
    rd_chk("R10 ident", 2'd2, 16'h001A);
    rd_chk("R10 unused word", 2'd3, 16'h0000);

    // R1 halt and run commands
    wctl(8'h21);
    check("R1 halt cmd", {15'b0, halt_cmd}, 16'h0001);
    wctl(8'h22);
    check("R1 run cmd", {15'b0, halt_cmd}, 16'h0000);

    // R2 single step waits for a boundary
    wctl(8'h21);
    wctl(8'h24);
    check("R2 step releases", {15'b0, halt_cmd}, 16'h0000);
    tick();
    check("R2 no boundary yet", {15'b0, halt_cmd}, 16'h0000);
    inst_boundary = 1;
    tick();
    inst_boundary = 0;
    check("R2 re-halt after boundary", {15'b0, halt_cmd}, 16'h0001);

    // R3 software breakpoint, enabled then disabled
    wctl(8'h0A);
    fetch_valid = 1; fetch_opcode = 16'h4343;
    tick();
    fetch_valid = 0;
    check("R3 sw break halts", {15'b0, halt_cmd}, 16'h0001);
    rd_chk("R3 sw pending", 2'd1, 16'h0009);
    wctl(8'h02);
    fetch_valid = 1;
    tick();
    fetch_valid = 0;
    check("R3 disabled opcode ignored", {15'b0, halt_cmd}, 16'h0000);
    wstat(8'h08);
    rd_chk("R6 write-one clears", 2'd1, 16'h0000);

    // R4 break after system reset
    wctl(8'h20);
    sys_rst = 1;
    tick();
    sys_rst = 0;
    rd_chk("R4 reset break and pending", 2'd1, 16'h0003);

    // R5 hardware breakpoint unit 1
    wctl(8'h22);
    hwbrk_stop = 2'b10;
    tick();
    hwbrk_stop = 0;
    rd_chk("R5 hw stop and pending", 2'd1, 16'h0023);

    // R7 freeze follows enable and halted state
    wctl(8'h30);
    check("R7 freeze while halted", {15'b0, freeze}, 16'h0001);
    wctl(8'h32);
    check("R7 freeze drops on run", {15'b0, freeze}, 16'h0000);

    // R8 cpu reset pulse
    wctl(8'h60);
    check("R8 reset pulse high", {15'b0, cpu_reset}, 16'h0001);
    tick();
    check("R8 reset pulse ends", {15'b0, cpu_reset}, 16'h0000);

    // R6 event wins over clear
    hwbrk_stop = 2'b10;
    wstat(8'h20);
    hwbrk_stop = 0;
    rd_chk("R6 set wins", 2'd1, 16'h0023);
    wstat(8'h3A);
    rd_chk("R6 clear all", 2'd1, 16'h0001);

    // R9 debug enable low, through the synchronizer
    wctl(8'h18);
    rd_chk("R10 ctrl readback", 2'd0, 16'h0018);
    dbg_enable = 0;
    tick();
    tick();
    check("R9 still halted during sync", {15'b0, halt_cmd}, 16'h0001);
    tick();
    check("R9 cleared on third edge", {15'b0, halt_cmd}, 16'h0000);
    rd_chk("R9 ctrl back to default", 2'd0, 16'h0020);
    wctl(8'h01);
    check("R9 writes ignored while off", {15'b0, halt_cmd}, 16'h0000);
    dbg_enable = 1;
    repeat (3) tick();

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      dbg_enable    = ($urandom_range(0, 49) != 0);
      wr_en         = ($urandom_range(0, 3) == 0);
      wr_sel        = 1'($urandom_range(0, 1));
      wr_data       = 8'($urandom_range(0, 255));
      rd_sel        = 2'($urandom_range(0, 3));
      fetch_valid   = ($urandom_range(0, 1) == 1);
      fetch_opcode  = ($urandom_range(0, 1) == 1) ? 16'h4343 : 16'($urandom_range(0, 65535));
      inst_boundary = ($urandom_range(0, 2) == 0);
      sys_rst       = ($urandom_range(0, 39) == 0);
      hwbrk_stop[0] = ($urandom_range(0, 29) == 0);
      hwbrk_stop[1] = ($urandom_range(0, 29) == 0);
      tick();
    end

    finish_run();
  end

endmodule